// File: doc/BRIEF.md
# Overlapping Multi-Bank Window Router

This block sits between a display engine's address space and a set of nine independent video RAM banks. The address space is split into 16 KiB pages, called slots. A per-slot mask table, supplied from outside, says which banks answer in each slot, and several banks may be mapped into the same slot. A write goes out to every bank mapped in the addressed slot in the same cycle. A read enables every mapped bank in parallel. One cycle later, the bitwise OR of their returned words is presented together with a valid flag.

Two windows share the access port, and the address picks between them. Addresses inside a 2 MiB region at a configurable base use the primary window: 32 slots taken from address bits 18..14, which may contain banks 0 to 6. Every other address uses the secondary window: 8 slots taken from address bits 16..14, which may contain only banks 2, 7 and 8. Each bank sees the byte offset after its own size mask is applied, as a word address. Each bank also receives a 512-byte dirty-region index so that a cache beside it can track what was modified. Building the mask tables from control registers is done elsewhere.

Top module: `bankroute_top`

## Requirements
- R1: After reset, rd_valid_o and rd_data_o are 0, and no bank read or write enable is active while neither strobe is asserted.
- R2: An address whose bits 31..21 equal those of ENG_A_BASE (default 0x0600_0000) selects the primary table, with slot = addr[18:14]. Any other address selects the secondary table, with slot = addr[16:14]. Slot s occupies bits [s*9 +: 9] of its table, and bit n of that field stands for bank n.
- R3: Only primary-legal banks 0..6 (mask 0x07F) and secondary-legal banks 2, 7, 8 (mask 0x184) take part. Any other bit set in a slot mask enables nothing.
- R4: A read with wr_i low raises rd_valid_o exactly one cycle later. In that cycle rd_data_o is the OR of the words returned by every mapped legal bank.
- R5: A read of a slot with no legal bank mapped returns rd_valid_o = 1 and rd_data_o = 0.
- R6: A write asserts bank_we_o for every mapped legal bank in the same cycle, with bank_wdata_o equal to wdata_i.
- R7: Bank n receives word address ((addr & M_n) >> 2) in bank_addr_o[n*15 +: 15]. M_n is 0x1FFFF for banks 0..3, 0xFFFF for bank 4, 0x7FFF for bank 7, and 0x3FFF for banks 5, 6 and 8.
- R8: Bank n receives dirty index ((addr & M_n) >> 9) in bank_dirty_o[n*8 +: 8]. That index is the region marked by a write strobe on bank n.
- R9: When rd_i and wr_i are both high, the write is performed, no bank read enable is raised, and rd_valid_o stays low in the next cycle.
- R10: With neither strobe asserted, all bank read and write enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 32 | Byte address of the access |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | DW | Write data |
| map_a_i | input | 32*9 | Primary slot mask table |
| map_b_i | input | 8*9 | Secondary slot mask table |
| rd_valid_o | output | 1 | Read result valid, one cycle after the strobe |
| rd_data_o | output | DW | OR of the mapped banks' words |
| bank_re_o | output | 9 | Per-bank read enable |
| bank_we_o | output | 9 | Per-bank write enable |
| bank_addr_o | output | 9*15 | Per-bank masked word address |
| bank_wdata_o | output | DW | Write data shared by all banks |
| bank_dirty_o | output | 9*8 | Per-bank 512-byte region index |
| bank_rdata_i | input | 9*DW | Per-bank synchronous read data |

## Verification
A read strobe and a write strobe can land in the same cycle on the one address port, and the write must win. The bench raises both strobes at once on a slot that maps two banks. It then checks that both write enables fire and no read enable fires, and that no valid result appears in the next cycle. A later plain read then confirms that the broadcast data reached both banks, because their OR equals the written word.

// File: rtl/bankroute_pkg.sv
package bankroute_pkg;
  localparam int NB       = 9;
  localparam int ADDR_W   = 32;
  localparam int OFS_W    = 17;
  localparam int GRAIN_LG = 9;
  localparam int BA_W     = OFS_W - 2;
  localparam int DI_W     = OFS_W - GRAIN_LG;

  // per-bank byte offset mask (bank size minus one)
  function automatic logic [OFS_W-1:0] size_mask(input int b);
    case (b)
      0, 1, 2, 3: size_mask = 17'h1FFFF;
      4:          size_mask = 17'h0FFFF;
      7:          size_mask = 17'h07FFF;
      default:    size_mask = 17'h03FFF;
    endcase
  endfunction

  function automatic logic [BA_W-1:0] bank_word(input logic [OFS_W-1:0] ofs, input int b);
    logic [OFS_W-1:0] m;
    m = ofs & size_mask(b);
    bank_word = m[OFS_W-1:2];
  endfunction

  function automatic logic [DI_W-1:0] dirty_region(input logic [OFS_W-1:0] ofs, input int b);
    logic [OFS_W-1:0] m;
    m = ofs & size_mask(b);
    dirty_region = m[OFS_W-1:GRAIN_LG];
  endfunction
endpackage

// File: rtl/bankroute_slot_decode.sv
module bankroute_slot_decode
  import bankroute_pkg::*;
#(
  parameter logic [ADDR_W-1:0] ENG_A_BASE = 32'h0600_0000,
  parameter int                WIN_LG     = 21,
  parameter int                SLOT_LG    = 14,
  parameter int                SLOT_A_W   = 5,
  parameter int                SLOT_B_W   = 3,
  parameter logic [NB-1:0]     LEGAL_A    = 9'h07F,
  parameter logic [NB-1:0]     LEGAL_B    = 9'h184
) (
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [(1<<SLOT_A_W)*NB-1:0]     map_a_i,
  input  logic [(1<<SLOT_B_W)*NB-1:0]     map_b_i,
  output logic                            eng_a_o,
  output logic [NB-1:0]                   slot_mask_o
);
  logic [SLOT_A_W-1:0] slot_a;
  logic [SLOT_B_W-1:0] slot_b;
  logic [NB-1:0]       raw_a, raw_b;

  assign eng_a_o = (addr_i[ADDR_W-1:WIN_LG] == ENG_A_BASE[ADDR_W-1:WIN_LG]);
  assign slot_a  = addr_i[SLOT_LG +: SLOT_A_W];
  assign slot_b  = addr_i[SLOT_LG +: SLOT_B_W];
  assign raw_a   = map_a_i[slot_a*NB +: NB];
  assign raw_b   = map_b_i[slot_b*NB +: NB];

  always_comb begin
    if (eng_a_o) slot_mask_o = raw_a & LEGAL_A;
    else         slot_mask_o = raw_b & LEGAL_B;
  end
endmodule

// File: rtl/bankroute_fanout.sv
module bankroute_fanout
  import bankroute_pkg::*;
(
  input  logic [OFS_W-1:0]     ofs_i,
  input  logic                 rd_i,
  input  logic                 wr_i,
  input  logic [NB-1:0]        slot_mask_i,
  output logic [NB-1:0]        bank_re_o,
  output logic [NB-1:0]        bank_we_o,
  output logic [NB*BA_W-1:0]   bank_addr_o,
  output logic [NB*DI_W-1:0]   bank_dirty_o
);
  logic wr_go, rd_go;
  assign wr_go = wr_i;
  assign rd_go = rd_i & ~wr_i;   // write wins on a shared cycle

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign bank_we_o[b]                 = wr_go & slot_mask_i[b];
    assign bank_re_o[b]                 = rd_go & slot_mask_i[b];
    assign bank_addr_o[b*BA_W +: BA_W]  = bank_word(ofs_i, b);
    assign bank_dirty_o[b*DI_W +: DI_W] = dirty_region(ofs_i, b);
  end
endmodule

// File: rtl/bankroute_read_merge.sv
module bankroute_read_merge
  import bankroute_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_go_i,
  input  logic [NB-1:0]     rd_sel_i,
  input  logic [NB*DW-1:0]  bank_rdata_i,
  output logic              rd_valid_o,
  output logic [DW-1:0]     rd_data_o
);
  logic [NB-1:0] sel_q;
  logic          vld_q;
  logic [DW-1:0] merged;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= rd_go_i;
      sel_q <= rd_go_i ? rd_sel_i : '0;
    end
  end

  always_comb begin
    merged = '0;
    for (int b = 0; b < NB; b++)
      if (sel_q[b]) merged = merged | bank_rdata_i[b*DW +: DW];
  end

  assign rd_valid_o = vld_q;
  assign rd_data_o  = vld_q ? merged : '0;

  // R5: no bank mapped -> zero word
  a_r5_empty_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_valid_o && sel_q == '0) |-> rd_data_o == '0);
endmodule

// File: rtl/bankroute_top.sv
module bankroute_top
  import bankroute_pkg::*;
#(
  parameter int                DW         = 32,
  parameter logic [ADDR_W-1:0] ENG_A_BASE = 32'h0600_0000,
  parameter int                SLOT_A_W   = 5,
  parameter int                SLOT_B_W   = 3,
  parameter logic [NB-1:0]     LEGAL_A    = 9'h07F,
  parameter logic [NB-1:0]     LEGAL_B    = 9'h184
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic                          rd_i,
  input  logic                          wr_i,
  input  logic [DW-1:0]                 wdata_i,
  input  logic [(1<<SLOT_A_W)*NB-1:0]   map_a_i,
  input  logic [(1<<SLOT_B_W)*NB-1:0]   map_b_i,
  output logic                          rd_valid_o,
  output logic [DW-1:0]                 rd_data_o,
  output logic [NB-1:0]                 bank_re_o,
  output logic [NB-1:0]                 bank_we_o,
  output logic [NB*BA_W-1:0]            bank_addr_o,
  output logic [DW-1:0]                 bank_wdata_o,
  output logic [NB*DI_W-1:0]            bank_dirty_o,
  input  logic [NB*DW-1:0]              bank_rdata_i
);
  logic          eng_a;
  logic [NB-1:0] slot_mask;
  logic          rd_go;

  bankroute_slot_decode #(
    .ENG_A_BASE(ENG_A_BASE), .WIN_LG(21), .SLOT_LG(14),
    .SLOT_A_W(SLOT_A_W), .SLOT_B_W(SLOT_B_W),
    .LEGAL_A(LEGAL_A), .LEGAL_B(LEGAL_B)
  ) u_dec (
    .addr_i(addr_i), .map_a_i(map_a_i), .map_b_i(map_b_i),
    .eng_a_o(eng_a), .slot_mask_o(slot_mask)
  );

  bankroute_fanout u_fan (
    .ofs_i(addr_i[OFS_W-1:0]), .rd_i(rd_i), .wr_i(wr_i),
    .slot_mask_i(slot_mask),
    .bank_re_o(bank_re_o), .bank_we_o(bank_we_o),
    .bank_addr_o(bank_addr_o), .bank_dirty_o(bank_dirty_o)
  );

  assign rd_go        = rd_i & ~wr_i;
  assign bank_wdata_o = wdata_i;

  bankroute_read_merge #(.DW(DW)) u_merge (
    .clk(clk), .rst(rst), .rd_go_i(rd_go), .rd_sel_i(bank_re_o),
    .bank_rdata_i(bank_rdata_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
  );

  // R9: write wins over a same-cycle read
  a_r9_write_wins: assert property (@(posedge clk) disable iff (rst)
    (rd_i && wr_i) |=> !rd_valid_o);
  // R4: fixed one-cycle read latency
  a_r4_latency: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !wr_i) |=> rd_valid_o);
  // R3: enables stay inside the selected window's legal set
  a_r3_legal_only: assert property (@(posedge clk) disable iff (rst)
    ((bank_we_o | bank_re_o) & ~(eng_a ? LEGAL_A : LEGAL_B)) == '0);
  // R10: idle port drives no bank
  a_r10_idle: assert property (@(posedge clk) disable iff (rst)
    (!rd_i && !wr_i) |-> (bank_we_o == '0 && bank_re_o == '0));
endmodule

// File: tb/bankroute_top_bench.sv
`timescale 1ns/1ps
module bankroute_top_bench;
  localparam int NBK = 9;
  localparam int W   = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [31:0]       addr = '0;
  logic              rd = 1'b0, wr = 1'b0;
  logic [W-1:0]      wdata = '0;
  logic [32*NBK-1:0] map_a = '0;
  logic [8*NBK-1:0]  map_b = '0;
  logic              rd_valid;
  logic [W-1:0]      rd_data;
  logic [NBK-1:0]    bre, bwe;
  logic [NBK*15-1:0] baddr;
  logic [W-1:0]      bwdata;
  logic [NBK*8-1:0]  bdirty;
  logic [NBK*W-1:0]  brdata = '0;

  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  bankroute_top u_bankroute_top (
    .clk(clk), .rst(rst), .addr_i(addr), .rd_i(rd), .wr_i(wr), .wdata_i(wdata),
    .map_a_i(map_a), .map_b_i(map_b), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .bank_re_o(bre), .bank_we_o(bwe), .bank_addr_o(baddr), .bank_wdata_o(bwdata),
    .bank_dirty_o(bdirty), .bank_rdata_i(brdata)
  );

  // synchronous bank RAM models, sparse
  logic [W-1:0] mem [int];
  always @(posedge clk) begin
    for (int b = 0; b < NBK; b++) begin
      int key;
      key = b * 32768 + int'(baddr[b*15 +: 15]);
      if (bre[b]) brdata[b*W +: W] <= mem.exists(key) ? mem[key] : '0;
      if (bwe[b]) mem[key] = bwdata;
    end
  end

  function automatic logic [16:0] bmask(input int b);
    if (b < 4) return 17'h1FFFF;
    if (b == 4) return 17'h0FFFF;
    if (b == 7) return 17'h07FFF;
    return 17'h03FFF;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_a(input int slot, input logic [8:0] m); map_a[slot*9 +: 9] = m; endtask
  task automatic set_b(input int slot, input logic [8:0] m); map_b[slot*9 +: 9] = m; endtask

  // drive one access at a negedge; strobe seen at the following posedge
  task automatic start(input logic r, input logic w, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    rd = r; wr = w; addr = a; wdata = d;
    #1;
  endtask

  task automatic finish_cycle();
    @(negedge clk);
    rd = 1'b0; wr = 1'b0;
    #1;
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d);
    start(1'b0, 1'b1, a, d);
    finish_cycle();
  endtask

  task automatic do_read(input logic [31:0] a, output logic [31:0] q, output logic v);
    start(1'b1, 1'b0, a, '0);
    finish_cycle();
    q = rd_data; v = rd_valid;
  endtask

  task automatic t_reset();
    check("R1 valid", {31'b0, rd_valid}, 32'h0);
    check("R1 data", rd_data, 32'h0);
    check("R1 enables", {14'b0, bre, bwe}, 32'h0);
  endtask

  task automatic t_broadcast();
    logic [31:0] q; logic v;
    set_a(0, 9'h003);
    start(1'b0, 1'b1, 32'h0600_0010, 32'h1111_2222);
    check("R6 we set", {23'b0, bwe}, 32'h003);
    check("R6 wdata", bwdata, 32'h1111_2222);
    check("R7 bank0 addr", {17'b0, baddr[0 +: 15]}, 32'h4);
    finish_cycle();
    set_a(0, 9'h002);
    do_read(32'h0600_0010, q, v);
    check("R6 bank1 got data", q, 32'h1111_2222);
    check("R4 valid", {31'b0, v}, 32'h1);
    check("R4 valid drops", {31'b0, rd_valid}, 32'h1);
    @(negedge clk); #1;
    check("R4 one-shot valid", {31'b0, rd_valid}, 32'h0);
  endtask

  task automatic t_or_read();
    logic [31:0] q; logic v;
    set_a(2, 9'h001); do_write(32'h0600_8020, 32'h0000_00F0);
    set_a(2, 9'h002); do_write(32'h0600_8020, 32'h0F00_0000);
    set_a(2, 9'h003);
    start(1'b1, 1'b0, 32'h0600_8020, '0);
    check("R4 both read enables", {23'b0, bre}, 32'h003);
    finish_cycle();
    check("R4 OR result", rd_data, 32'h0F00_00F0);
  endtask

  task automatic t_empty_and_illegal();
    logic [31:0] q; logic v;
    set_a(5, 9'h000);
    do_read(32'h0601_4000, q, v);
    check("R5 empty valid", {31'b0, v}, 32'h1);
    check("R5 empty data", q, 32'h0);
    set_a(3, 9'h180);
    start(1'b0, 1'b1, 32'h0600_C000, 32'hDEAD_BEEF);
    check("R3 illegal bits no write", {23'b0, bwe}, 32'h0);
    finish_cycle();
    do_read(32'h0600_C000, q, v);
    check("R3 illegal bits read zero", q, 32'h0);
  endtask

  task automatic t_engine_b();
    set_a(1, 9'h008);
    set_b(1, 9'h185);
    start(1'b0, 1'b1, 32'h0620_4000, 32'h5555_AAAA);
    check("R2 R3 secondary set", {23'b0, bwe}, 32'h184);
    finish_cycle();
    start(1'b0, 1'b1, 32'h0624_4000, 32'h1);
    check("R2 secondary slot ignores bit18", {23'b0, bwe}, 32'h184);
    finish_cycle();
    start(1'b0, 1'b1, 32'h0600_4000, 32'h2);
    check("R2 primary slot1", {23'b0, bwe}, 32'h008);
    finish_cycle();
  endtask

  task automatic t_size_masks();
    logic [31:0] a;
    set_a(31, 9'h031);
    a = 32'h0607_FFFC;
    start(1'b0, 1'b1, a, 32'h7);
    for (int b = 0; b < NBK; b++) begin
      logic [16:0] m;
      m = a[16:0] & bmask(b);
      if (b == 0 || b == 4 || b == 5) begin
        check($sformatf("R7 addr bank%0d", b), {17'b0, baddr[b*15 +: 15]}, {17'b0, m[16:2]});
        check($sformatf("R8 dirty bank%0d", b), {24'b0, bdirty[b*8 +: 8]}, {24'b0, m[16:9]});
      end
    end
    finish_cycle();
    set_b(1, 9'h080);
    a = 32'h0620_7FFC;
    start(1'b0, 1'b1, a, 32'h9);
    check("R7 addr bank7", {17'b0, baddr[7*15 +: 15]}, 32'h1FFF);
    check("R8 dirty bank7", {24'b0, bdirty[7*8 +: 8]}, 32'h3F);
    finish_cycle();
  endtask

  task automatic t_collide();
    logic [31:0] q; logic v;
    set_a(6, 9'h003);
    start(1'b1, 1'b1, 32'h0601_8040, 32'hCAFE_0001);
    check("R9 writes fire", {23'b0, bwe}, 32'h003);
    check("R9 no read enable", {23'b0, bre}, 32'h0);
    finish_cycle();
    check("R9 no valid", {31'b0, rd_valid}, 32'h0);
    do_read(32'h0601_8040, q, v);
    check("R9 broadcast landed", q, 32'hCAFE_0001);
  endtask

  task automatic t_idle();
    @(negedge clk); rd = 0; wr = 0; addr = 32'h0600_0010; #1;
    check("R10 idle", {14'b0, bre, bwe}, 32'h0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    t_reset();
    t_broadcast();
    t_or_read();
    t_empty_and_illegal();
    t_engine_b();
    t_size_masks();
    t_collide();
    t_idle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule